// File: doc/BRIEF.md
# Banked Divide-Select Clock Fanout

This block distributes one input clock to four output banks of five lines each. Every bank has its own rate select. With the select high, the bank carries the input clock as it is. With the select low, the bank carries a half-rate copy. Banks may run at different rates at the same time. All half-rate banks take their signal from one shared divide-by-two flop, so they stay in phase with each other.

A two-bit enable code sets how many banks are driven. The driven set always grows from the first bank, and the remaining banks float. An active-low master control does two jobs: when low, it floats every bank and holds the divider cleared. The high-impedance state is modelled as a per-bank output-enable signal next to each bank's five data lines, instead of as tristate pads.

Top module: `clk_fanout_banks`

## Requirements
- R1: While `mr_oe_n` is low, every bit of `bank_oe` is 0 and every bit of `bank_q` is 0, whatever the other inputs are. This follows `mr_oe_n` with no clock edge in between.
- R2: While `mr_oe_n` is high, bank 0 (`bank_oe[0]`, `bank_q[4:0]`) is enabled for every value of `bank_en`.
- R3: With `mr_oe_n` high, the code {`bank_en[1]`,`bank_en[0]`} decodes as follows: 00 enables bank 0 only; 10 enables banks 0 and 1; 01 enables banks 0 to 2; 11 enables all four banks.
- R4: A bank whose `bank_oe` bit is 0 drives 0 on all five of its `bank_q` bits.
- R5: An enabled bank b with `div_sel[b]` = 1 drives the level of `clk_in` on all five of its bits, `bank_q[5b+4:5b]`.
- R6: An enabled bank with `div_sel[b]` = 0 drives the shared half-rate signal on all five bits. All half-rate banks carry identical values in the same cycle, including when other banks are at full rate.
- R7: The half-rate signal changes only on rising edges of `clk_in`. Counting rising edges sampled with `mr_oe_n` high after a release, it is 0 after edges 1 and 2 are not yet both seen (0 after edge 1), becomes 1 at edge 2, and then toggles at every edge.
- R8: A rising edge that samples `mr_oe_n` low clears the divider. Restart after the next release follows R7 from the start, even if the low phase lasted only one cycle.
- R9: Changes to `div_sel` and `bank_en` reach `bank_q` and `bank_oe` within the same clock phase, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; source of full-rate banks and of the divider |
| mr_oe_n | input | 1 | Active-low master enable; low floats all banks and clears the divider |
| bank_en | input | 2 | Nested bank-enable code |
| div_sel | input | 4 | Per-bank rate select: 1 full rate, 0 half rate |
| bank_q | output | 20 | Bank data, five bits per bank, bank b at bits 5b+4:5b |
| bank_oe | output | 4 | Per-bank output enable; 0 models high impedance |

## Verification
Two events can land on the same rising edge: the master control dropping and the divider's scheduled toggle. The control must win, so the edge clears the divider instead of toggling it. The bench provokes this by dropping `mr_oe_n` for a single cycle at random points in a stream of random rate selects and enable codes. The bench keeps its own count of edges since release, and it checks that the outputs float in that same phase and that the half-rate signal restarts low, rising at the second edge after release. Select and code changes are made in the low phase of the clock and judged before the next edge, which separates their immediate effect from the divider's edge-driven behaviour.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  // Reverses the bit order of the enable code so that the nested bank
  // count becomes a plain binary value.
  function automatic logic [1:0] rev2(input logic [1:0] code);
    return {code[0], code[1]};
  endfunction

endpackage

// File: rtl/clkfan_div2.sv
module clkfan_div2 (
  input  logic clk_in,
  input  logic hold_rst,
  output logic half_q
);

  logic run_q;

  // A one-edge start-up stage keeps the first rising edge of the
  // half-rate signal on the second input edge after release.
  always_ff @(posedge clk_in) begin
    if (hold_rst) begin
      run_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (run_q) half_q <= ~half_q;
    end
  end

endmodule

// File: rtl/clkfan_en_decode.sv
module clkfan_en_decode #(
  parameter int NUM_BANKS = 4,
  parameter int EN_W      = 2
) (
  input  logic                 mr_oe_n,
  input  logic [EN_W-1:0]      code,
  output logic [NUM_BANKS-1:0] oe
);

  logic [EN_W-1:0] depth;

  // Bit-reverse the code: the result is the index of the last driven bank.
  generate
    for (genvar k = 0; k < EN_W; k++) begin : g_rev
      assign depth[k] = code[EN_W-1-k];
    end
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_oe
      assign oe[g] = mr_oe_n && (EN_W'(g) <= depth);
    end
  endgenerate

endmodule

// File: rtl/clkfan_bank_mux.sv
module clkfan_bank_mux #(
  parameter int BANK_W = 5
) (
  input  logic              clk_src,
  input  logic              half_src,
  input  logic              full_rate,
  input  logic              oe,
  output logic [BANK_W-1:0] q
);

  logic pick;

  always_comb begin
    pick = full_rate ? clk_src : half_src;
    q    = oe ? {BANK_W{pick}} : '0;
  end

endmodule

// File: rtl/clk_fanout_banks.sv
module clk_fanout_banks #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 5,
  localparam int EN_W     = $clog2(NUM_BANKS),
  localparam int OUT_W    = NUM_BANKS * BANK_W
) (
  input  logic                 clk_in,
  input  logic                 mr_oe_n,
  input  logic [EN_W-1:0]      bank_en,
  input  logic [NUM_BANKS-1:0] div_sel,
  output logic [OUT_W-1:0]     bank_q,
  output logic [NUM_BANKS-1:0] bank_oe
);

  logic half_sig;
  logic hold_rst;

  assign hold_rst = ~mr_oe_n;

  clkfan_div2 u_div (
    .clk_in   (clk_in),
    .hold_rst (hold_rst),
    .half_q   (half_sig)
  );

  clkfan_en_decode #(
    .NUM_BANKS (NUM_BANKS),
    .EN_W      (EN_W)
  ) u_dec (
    .mr_oe_n (mr_oe_n),
    .code    (bank_en),
    .oe      (bank_oe)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      clkfan_bank_mux #(
        .BANK_W (BANK_W)
      ) u_mux (
        .clk_src   (clk_in),
        .half_src  (half_sig),
        .full_rate (div_sel[b]),
        .oe        (bank_oe[b]),
        .q         (bank_q[b*BANK_W +: BANK_W])
      );
    end
  endgenerate

endmodule

// File: rtl/clkfan_checker.sv
module clkfan_checker #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 5
) (
  input logic                        clk_in,
  input logic                        mr_oe_n,
  input logic                        half_q,
  input logic [NUM_BANKS-1:0]        bank_oe,
  input logic [NUM_BANKS*BANK_W-1:0] bank_q
);

  assert_float_all_R1: assert property (@(posedge clk_in)
    !mr_oe_n |-> (bank_oe == '0))
    else $error("R1 enables active while master low");

  assert_first_bank_R2: assert property (@(posedge clk_in)
    mr_oe_n |-> bank_oe[0])
    else $error("R2 bank 0 off while master high");

  // R3: the driven set is always a run starting at bank 0.
  assert_nested_R3: assert property (@(posedge clk_in)
    ((bank_oe + 1'b1) & bank_oe) == '0)
    else $error("R3 enable set not nested");

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
      assert_off_low_R4: assert property (@(posedge clk_in)
        !bank_oe[g] |-> (bank_q[g*BANK_W +: BANK_W] == '0))
        else $error("R4 disabled bank drives data");
    end
  endgenerate

  assert_start_low_R7: assert property (@(posedge clk_in) disable iff (!mr_oe_n)
    ($past(mr_oe_n) && !$past(mr_oe_n, 2)) |-> (half_q == 1'b0))
    else $error("R7 half-rate not low after first edge");

  assert_toggle_R7: assert property (@(posedge clk_in) disable iff (!mr_oe_n)
    ($past(mr_oe_n) && $past(mr_oe_n, 2)) |-> (half_q != $past(half_q)))
    else $error("R7 half-rate failed to toggle");

  assert_clear_R8: assert property (@(posedge clk_in)
    $past(!mr_oe_n) |-> (half_q == 1'b0))
    else $error("R8 divider not cleared");

endmodule

bind clk_fanout_banks clkfan_checker #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W)
) u_chk (
  .clk_in  (clk_in),
  .mr_oe_n (mr_oe_n),
  .half_q  (half_sig),
  .bank_oe (bank_oe),
  .bank_q  (bank_q)
);

// File: tb/clk_fanout_banks_tb.sv
module clk_fanout_banks_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int BW = 5;

  logic          clk_in = 1'b0;
  logic          mr_oe_n = 1'b0;
  logic [1:0]    bank_en = 2'b11;
  logic [NB-1:0] div_sel = '1;
  logic [NB*BW-1:0] bank_q;
  logic [NB-1:0] bank_oe;

  int tests = 0;
  int fails = 0;
  int n_edges = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_in = ~clk_in;

  clk_fanout_banks u_dut (
    .clk_in  (clk_in),
    .mr_oe_n (mr_oe_n),
    .bank_en (bank_en),
    .div_sel (div_sel),
    .bank_q  (bank_q),
    .bank_oe (bank_oe)
  );

  // R3 table: number of driven banks per code {en1,en0}
  function automatic logic [NB-1:0] exp_oe(input logic mr, input logic [1:0] en);
    if (!mr) return '0;
    case (en)
      2'b00:   return 4'b0001;
      2'b10:   return 4'b0011;
      2'b01:   return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  // R7: half-rate level after n counted edges since release
  function automatic logic exp_half(input int n);
    return (n >= 2) && (n % 2 == 0);
  endfunction

  function automatic logic [NB*BW-1:0] exp_q(input logic [NB-1:0] oe,
      input logic [NB-1:0] sel, input logic clk_lvl, input logic half);
    logic [NB*BW-1:0] r;
    r = '0;
    for (int b = 0; b < NB; b++)
      if (oe[b]) r[b*BW +: BW] = {BW{sel[b] ? clk_lvl : half}};
    return r;
  endfunction

  task automatic check(input string tag);
    logic [NB-1:0]    eo;
    logic [NB*BW-1:0] eq;
    eo = exp_oe(mr_oe_n, bank_en);
    eq = exp_q(eo, div_sel, clk_in, exp_half(n_edges));
    tests++;
    if (bank_oe !== eo || bank_q !== eq) begin
      fails++;
      $display("FAIL %s: oe=%h q=%h expected oe=%h q=%h", tag, bank_oe, bank_q, eo, eq);
    end
  endtask

  task automatic step(input logic mr, input logic [1:0] en, input logic [NB-1:0] sel,
      input string tag);
    @(negedge clk_in);
    mr_oe_n = mr;
    bank_en = en;
    div_sel = sel;
    #1 check(tag);   // R9: new inputs visible in this phase
    @(posedge clk_in);
    n_edges = mr ? n_edges + 1 : 0;
    #1 check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state, any other inputs
    step(1'b0, 2'b11, 4'b1111, "R1 hold");
    step(1'b0, 2'b01, 4'b0000, "R1 hold");
    step(1'b0, 2'b00, 4'b1010, "R1 hold");
    // R7 release with every bank at half rate
    for (int i = 0; i < 6; i++) step(1'b1, 2'b11, 4'b0000, "R7 startup R6");
    // R3/R2 every code at full rate (R5)
    step(1'b1, 2'b00, 4'b1111, "R2 R3 code00 R5");
    step(1'b1, 2'b10, 4'b1111, "R3 code10 R5");
    step(1'b1, 2'b01, 4'b1111, "R3 code01 R4");
    step(1'b1, 2'b11, 4'b1111, "R3 code11");
    // R6 mixed rates
    step(1'b1, 2'b11, 4'b0101, "R6 mixed");
    step(1'b1, 2'b11, 4'b1010, "R6 mixed");
    // R8 one-cycle drop mid-run, then restart
    step(1'b0, 2'b11, 4'b0000, "R1 R8 drop");
    for (int i = 0; i < 4; i++) step(1'b1, 2'b11, 4'b0000, "R8 restart");
    // R9 random select/code changes, occasional drop
    for (int i = 0; i < 400; i++) begin
      logic m;
      m = ($urandom_range(0, 7) != 0);
      step(m, 2'($urandom), 4'($urandom), "R9 random R3 R4 R5 R6 R8");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule